// File: doc/BRIEF.md
# Sequenced Link Test Pattern Generator

The block produces a stream of 24-bit test words for a serial link self-test. It runs three pattern sources one after another, in one of six programmable orders:

- a small two-word pattern store, loaded through a write port;
- a modulo-N square-wave source;
- a constant source.

Each source has its own loop count, and a count of zero removes that source from the sequence. An overall loop count repeats the whole sequence of enabled sources.

A one-cycle start pulse begins a run while the block is idle. Words then leave on a 24-bit output qualified by a valid strobe, with no gap cycles inside the run. A one-cycle done flag marks the end of the run. The configuration inputs are expected to stay stable from the start pulse until the done flag.

Top module: `link_pattern_seq`

## Requirements
- R1: After reset, `wordValid` and `runDone` are 0 and `wordOut` is all zeros, and `wordOut` is all zeros in every cycle where `wordValid` is 0.
- R2: A start with `overallLoops` equal to 0 emits no words and still raises `runDone` for one cycle, in the second cycle after the start pulse.
- R3: With a nonzero `storeLoops` L, the store source emits 2·L words, alternating the word written at `storeWrAddr` 0 and the word written at address 1, starting with address 0.
- R4: With a nonzero `modLoops` M, the modulo-N source emits M identical words selected by `periodSel`: 001→555555h, 010→333333h, 011→1C71C7h, 100→0F0F0Fh, 110→000FFFh.
- R5: The `periodSel` codes 000, 101 and 111 make the modulo-N source emit no words, and the run still completes.
- R6: With a nonzero `constLoops` C, the constant source emits C words that are all zeros when `constBit` is 0 and all ones when it is 1.
- R7: `orderSel` sets the source sequence: 000 store,mod,const; 001 store,const,mod; 010 mod,store,const; 011 mod,const,store; 100 const,store,mod; 101 const,mod,store.
- R8: The `orderSel` codes 110 and 111 emit no words, and `runDone` still pulses.
- R9: A nonzero `overallLoops` N repeats the whole source sequence N times.
- R10: A source with a loop count of 0 is skipped without any idle cycle, so the valid words of a run occupy consecutive cycles, starting the second cycle after the start pulse.
- R11: `runDone` is high for exactly one cycle, in the cycle after the last word, and never together with `wordValid`.
- R12: A start pulse received during a run is ignored, and the run continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Starts a run when idle |
| overallLoops | input | 6 | Repeat count of the full sequence |
| storeLoops | input | 7 | Replay count of the pattern store |
| modLoops | input | 8 | Word count of the modulo-N source |
| constLoops | input | 5 | Word count of the constant source |
| constBit | input | 1 | Constant value: 0 all zeros, 1 all ones |
| periodSel | input | 3 | Modulo-N period code |
| orderSel | input | 3 | Source order code |
| storeWrEn | input | 1 | Pattern store write enable |
| storeWrAddr | input | 1 | Pattern store word address |
| storeWrData | input | 24 | Pattern store write data |
| wordOut | output | 24 | Test word |
| wordValid | output | 1 | `wordOut` carries a word |
| runDone | output | 1 | One-cycle end-of-run flag |

## Verification
Two events can fall in the same cycle at the end of a pass: a source reaching its last word, and the sequencer both skipping disabled sources and wrapping into the next overall loop. The bench provokes this with orders that put a disabled source last, and with several overall loops. It judges the result by requiring valid words in strictly consecutive cycles, with contents that match a stream it builds itself from the requirements. A second collision is a start pulse arriving while a run is in progress. That case is judged by the stream being unchanged, and by the block being idle one cycle after `runDone`.

// File: rtl/link_pattern_pkg.sv
package link_pattern_pkg;
  localparam int WORD_W      = 24;
  localparam int STORE_DEPTH = 2;
  localparam int ADDR_W      = $clog2(STORE_DEPTH);
  localparam int OVR_W       = 6;
  localparam int STORE_LW    = 7;
  localparam int MOD_LW      = 8;
  localparam int CONST_LW    = 5;
  localparam int STORE_TW    = STORE_LW + ADDR_W;
  localparam int CNT_A       = (STORE_TW > MOD_LW) ? STORE_TW : MOD_LW;
  localparam int CNT_W       = (CNT_A > CONST_LW) ? CNT_A : CONST_LW;
  localparam int NUM_SLOTS   = 3;

  typedef enum logic [1:0] {SRC_STORE = 2'd0, SRC_MOD = 2'd1, SRC_CONST = 2'd2} srcSel_e;

  typedef struct packed {
    logic             emit;
    srcSel_e          src;
    logic [CNT_W-1:0] wordIdx;
  } strobe_t;

  function automatic logic orderLegal(input logic [2:0] code);
    return code <= 3'd5;
  endfunction

  function automatic srcSel_e orderSlot(input logic [2:0] code, input logic [1:0] slot);
    srcSel_e a, b, c;
    case (code)
      3'd0: begin a = SRC_STORE; b = SRC_MOD;   c = SRC_CONST; end
      3'd1: begin a = SRC_STORE; b = SRC_CONST; c = SRC_MOD;   end
      3'd2: begin a = SRC_MOD;   b = SRC_STORE; c = SRC_CONST; end
      3'd3: begin a = SRC_MOD;   b = SRC_CONST; c = SRC_STORE; end
      3'd4: begin a = SRC_CONST; b = SRC_STORE; c = SRC_MOD;   end
      3'd5: begin a = SRC_CONST; b = SRC_MOD;   c = SRC_STORE; end
      default: begin a = SRC_STORE; b = SRC_STORE; c = SRC_STORE; end
    endcase
    return (slot == 2'd0) ? a : (slot == 2'd1) ? b : c;
  endfunction

  function automatic logic periodLegal(input logic [2:0] code);
    return (code == 3'd1) || (code == 3'd2) || (code == 3'd3) || (code == 3'd4) || (code == 3'd6);
  endfunction
endpackage

// File: rtl/link_pattern_ctrl.sv
module link_pattern_ctrl
  import link_pattern_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic [OVR_W-1:0]    overallLoops,
  input  logic [STORE_LW-1:0] storeLoops,
  input  logic [MOD_LW-1:0]   modLoops,
  input  logic [CONST_LW-1:0] constLoops,
  input  logic [2:0]          periodSel,
  input  logic [2:0]          orderSel,
  output strobe_t             strobe,
  output logic                runDone
);
  logic             busy;
  logic [1:0]       slot;
  logic [OVR_W-1:0] passesLeft;
  logic [CNT_W-1:0] wordIdx;
  logic             finPend;

  logic [CNT_W-1:0] totStore, totMod, totConst;
  srcSel_e          slotSrc [NUM_SLOTS];
  logic [CNT_W-1:0] slotTot [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] active;
  logic [1:0]       cur;
  logic             afterActive;
  logic             lastWord;

  always_comb begin
    totStore = CNT_W'(storeLoops) * CNT_W'(STORE_DEPTH);
    totMod   = periodLegal(periodSel) ? CNT_W'(modLoops) : '0;
    totConst = CNT_W'(constLoops);
    for (int s = 0; s < NUM_SLOTS; s++) begin
      slotSrc[s] = orderSlot(orderSel, 2'(s));
      case (slotSrc[s])
        SRC_STORE: slotTot[s] = totStore;
        SRC_MOD:   slotTot[s] = totMod;
        default:   slotTot[s] = totConst;
      endcase
      active[s] = orderLegal(orderSel) && (slotTot[s] != '0);
    end
    // zero-cycle skip: first active slot at or after the current one
    cur = slot;
    for (int s = NUM_SLOTS - 1; s >= 0; s--)
      if (2'(s) >= slot && active[s]) cur = 2'(s);
    afterActive = 1'b0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (2'(s) > cur && active[s]) afterActive = 1'b1;
    lastWord = (wordIdx == slotTot[cur] - CNT_W'(1));
  end

  assign strobe.emit    = busy;
  assign strobe.src     = slotSrc[cur];
  assign strobe.wordIdx = wordIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      slot       <= '0;
      passesLeft <= '0;
      wordIdx    <= '0;
      finPend    <= 1'b0;
      runDone    <= 1'b0;
    end else begin
      finPend <= 1'b0;
      runDone <= finPend;
      if (!busy) begin
        if (startPulse) begin
          if (overallLoops != '0 && (|active)) begin
            busy       <= 1'b1;
            slot       <= '0;
            passesLeft <= overallLoops;
            wordIdx    <= '0;
          end else begin
            finPend <= 1'b1;
          end
        end
      end else if (lastWord) begin
        wordIdx <= '0;
        if (afterActive) begin
          slot <= cur + 2'd1;
        end else if (passesLeft > OVR_W'(1)) begin
          passesLeft <= passesLeft - OVR_W'(1);
          slot       <= '0;
        end else begin
          busy    <= 1'b0;
          finPend <= 1'b1;
        end
      end else begin
        wordIdx <= wordIdx + CNT_W'(1);
        slot    <= cur;
      end
    end
  end

  assert_single_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    runDone |=> !runDone);
  assert_empty_run_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startPulse && overallLoops == '0) |=> !busy);
  assert_busy_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastWord) |=> busy);
  assert_active_pick_R10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> active[cur]);
endmodule

// File: rtl/link_pattern_dp.sv
module link_pattern_dp
  import link_pattern_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [2:0]        periodSel,
  input  logic              constBit,
  input  logic              storeWrEn,
  input  logic [ADDR_W-1:0] storeWrAddr,
  input  logic [WORD_W-1:0] storeWrData,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  logic [WORD_W-1:0] storeMem [STORE_DEPTH];
  logic [WORD_W-1:0] modWord, nextWord;
  srcSel_e           srcQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STORE_DEPTH; i++) storeMem[i] <= '0;
    end else if (storeWrEn) begin
      storeMem[storeWrAddr] <= storeWrData;
    end
  end

  // bit i counted from the MSB is (i / half) mod 2 for each period
  for (genvar i = 0; i < WORD_W; i++) begin : g_modBit
    localparam logic B2  = ((i / 1)  % 2) == 1;
    localparam logic B4  = ((i / 2)  % 2) == 1;
    localparam logic B6  = ((i / 3)  % 2) == 1;
    localparam logic B8  = ((i / 4)  % 2) == 1;
    localparam logic B24 = ((i / 12) % 2) == 1;
    always_comb begin
      case (periodSel)
        3'd1:    modWord[WORD_W-1-i] = B2;
        3'd2:    modWord[WORD_W-1-i] = B4;
        3'd3:    modWord[WORD_W-1-i] = B6;
        3'd4:    modWord[WORD_W-1-i] = B8;
        3'd6:    modWord[WORD_W-1-i] = B24;
        default: modWord[WORD_W-1-i] = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (strobe.src)
      SRC_STORE: nextWord = storeMem[strobe.wordIdx[ADDR_W-1:0]];
      SRC_MOD:   nextWord = modWord;
      default:   nextWord = {WORD_W{constBit}};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordValid <= 1'b0;
      wordOut   <= '0;
      srcQ      <= SRC_STORE;
    end else begin
      wordValid <= strobe.emit;
      wordOut   <= strobe.emit ? nextWord : '0;
      srcQ      <= strobe.src;
    end
  end

  assert_const_uniform_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && srcQ == SRC_CONST) |-> (wordOut == '0 || wordOut == '1));
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> wordOut == '0);
endmodule

// File: rtl/link_pattern_seq.sv
module link_pattern_seq
  import link_pattern_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic [OVR_W-1:0]    overallLoops,
  input  logic [STORE_LW-1:0] storeLoops,
  input  logic [MOD_LW-1:0]   modLoops,
  input  logic [CONST_LW-1:0] constLoops,
  input  logic                constBit,
  input  logic [2:0]          periodSel,
  input  logic [2:0]          orderSel,
  input  logic                storeWrEn,
  input  logic [ADDR_W-1:0]   storeWrAddr,
  input  logic [WORD_W-1:0]   storeWrData,
  output logic [WORD_W-1:0]   wordOut,
  output logic                wordValid,
  output logic                runDone
);
  strobe_t strobe;

  link_pattern_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .overallLoops(overallLoops),
    .storeLoops(storeLoops), .modLoops(modLoops), .constLoops(constLoops),
    .periodSel(periodSel), .orderSel(orderSel), .strobe(strobe), .runDone(runDone));

  link_pattern_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .periodSel(periodSel), .constBit(constBit),
    .storeWrEn(storeWrEn), .storeWrAddr(storeWrAddr), .storeWrData(storeWrData),
    .wordOut(wordOut), .wordValid(wordValid));

  assert_done_apart_R11: assert property (@(posedge clk) disable iff (!rstN)
    runDone |-> !wordValid);
endmodule

// File: tb/tb_link_pattern_seq.sv
`timescale 1ns/1ps
module tb_link_pattern_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [5:0]  overallLoops = '0;
  logic [6:0]  storeLoops = '0;
  logic [7:0]  modLoops = '0;
  logic [4:0]  constLoops = '0;
  logic        constBit = 1'b0;
  logic [2:0]  periodSel = '0;
  logic [2:0]  orderSel = '0;
  logic        storeWrEn = 1'b0;
  logic        storeWrAddr = 1'b0;
  logic [23:0] storeWrData = '0;
  logic [23:0] wordOut;
  logic        wordValid, runDone;

  int nChecks = 0, nFails = 0;
  logic [23:0] expArr [0:4095];
  int expN;
  logic [23:0] storeCopy [0:1];

  always #5 clk = ~clk;

  link_pattern_seq dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .overallLoops(overallLoops),
    .storeLoops(storeLoops), .modLoops(modLoops), .constLoops(constLoops),
    .constBit(constBit), .periodSel(periodSel), .orderSel(orderSel),
    .storeWrEn(storeWrEn), .storeWrAddr(storeWrAddr), .storeWrData(storeWrData),
    .wordOut(wordOut), .wordValid(wordValid), .runDone(runDone));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic writeStore(input logic addr, input logic [23:0] data);
    @(negedge clk);
    storeWrEn = 1'b1; storeWrAddr = addr; storeWrData = data;
    @(negedge clk);
    storeWrEn = 1'b0;
    storeCopy[addr] = data;
  endtask

  function automatic logic [23:0] modPattern(input logic [2:0] code, output bit ok);
    ok = 1'b1;
    case (code)
      3'd1: return 24'h555555;
      3'd2: return 24'h333333;
      3'd3: return 24'h1C71C7;
      3'd4: return 24'h0F0F0F;
      3'd6: return 24'h000FFF;
      default: begin ok = 1'b0; return 24'h0; end
    endcase
  endfunction

  task automatic pushWord(input logic [23:0] w);
    if (expN < 4096) expArr[expN] = w;
    expN++;
  endtask

  task automatic emitSource(input int src);
    bit ok;
    logic [23:0] m;
    if (src == 0) begin
      for (int l = 0; l < storeLoops; l++) begin
        pushWord(storeCopy[0]);
        pushWord(storeCopy[1]);
      end
    end else if (src == 1) begin
      m = modPattern(periodSel, ok);
      if (ok) for (int l = 0; l < modLoops; l++) pushWord(m);
    end else begin
      for (int l = 0; l < constLoops; l++) pushWord(constBit ? 24'hFFFFFF : 24'h0);
    end
  endtask

  task automatic buildExp();
    int seq [3];
    expN = 0;
    case (orderSel)
      3'd0: seq = '{0, 1, 2};
      3'd1: seq = '{0, 2, 1};
      3'd2: seq = '{1, 0, 2};
      3'd3: seq = '{1, 2, 0};
      3'd4: seq = '{2, 0, 1};
      3'd5: seq = '{2, 1, 0};
      default: return;
    endcase
    for (int p = 0; p < overallLoops; p++)
      for (int s = 0; s < 3; s++) emitSource(seq[s]);
  endtask

  // Words expected in cycles 1..expN after the start edge, done in cycle expN+1.
  task automatic runCase(input string req, input int midStartAt);
    buildExp();
    @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    for (int cyc = 1; cyc <= expN + 2; cyc++) begin
      @(negedge clk);
      startPulse = (cyc == midStartAt);
      chk(wordValid == (cyc <= expN), req, "valid", 32'(wordValid), 32'(cyc <= expN));
      if (cyc <= expN)
        chk(wordOut == expArr[cyc-1], req, "word", 32'(wordOut), 32'(expArr[cyc-1]));
      else
        chk(wordOut == 24'h0, "R1", "idle word", 32'(wordOut), 32'h0);
      chk(runDone == (cyc == expN + 1), "R11", "done", 32'(runDone), 32'(cyc == expN + 1));
    end
    startPulse = 1'b0;
  endtask

  task automatic setCfg(input int ovr, input int sl, input int ml, input int cl,
                        input logic cb, input logic [2:0] per, input logic [2:0] ord);
    overallLoops = 6'(ovr); storeLoops = 7'(sl); modLoops = 8'(ml);
    constLoops = 5'(cl); constBit = cb; periodSel = per; orderSel = ord;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(wordValid == 1'b0, "R1", "reset valid", 32'(wordValid), 32'h0);
    chk(wordOut == 24'h0, "R1", "reset word", 32'(wordOut), 32'h0);
    chk(runDone == 1'b0, "R1", "reset done", 32'(runDone), 32'h0);
  endtask

  task automatic testStore();
    setCfg(1, 3, 0, 0, 1'b0, 3'd1, 3'd0);
    runCase("R3", 0);
  endtask

  task automatic testMod();
    for (int c = 0; c < 8; c++) begin
      setCfg(1, 0, 2, 0, 1'b0, 3'(c), 3'd0);
      runCase((c == 0 || c == 5 || c == 7) ? "R5" : "R4", 0);
    end
  endtask

  task automatic testConst();
    setCfg(1, 0, 0, 4, 1'b0, 3'd1, 3'd0);
    runCase("R6", 0);
    setCfg(1, 0, 0, 4, 1'b1, 3'd1, 3'd0);
    runCase("R6", 0);
  endtask

  task automatic testOrder();
    for (int o = 0; o < 6; o++) begin
      setCfg(1, 1, 1, 2, 1'b1, 3'd2, 3'(o));
      runCase("R7", 0);
    end
  endtask

  task automatic testReservedOrder();
    setCfg(2, 1, 1, 1, 1'b1, 3'd1, 3'd6);
    runCase("R8", 0);
    setCfg(2, 1, 1, 1, 1'b1, 3'd1, 3'd7);
    runCase("R8", 0);
  endtask

  task automatic testOverall();
    setCfg(3, 1, 2, 1, 1'b0, 3'd2, 3'd3);
    runCase("R9", 0);
  endtask

  task automatic testSkip();
    setCfg(2, 2, 0, 3, 1'b1, 3'd4, 3'd0);
    runCase("R10", 0);
    setCfg(2, 0, 3, 0, 1'b0, 3'd3, 3'd4);
    runCase("R10", 0);
  endtask

  task automatic testZero();
    setCfg(0, 2, 2, 2, 1'b1, 3'd1, 3'd0);
    runCase("R2", 0);
  endtask

  task automatic testMidStart();
    setCfg(1, 2, 3, 2, 1'b1, 3'd6, 3'd5);
    runCase("R12", 3);
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    writeStore(1'b0, 24'hA5C31E);
    writeStore(1'b1, 24'h5A3CE1);
    testStore();
    testMod();
    testConst();
    testOrder();
    testReservedOrder();
    testOverall();
    testSkip();
    testZero();
    testMidStart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule